// File: doc/BRIEF.md
# Word Lane Extract and Replicate Unit

A purely combinational data-alignment stage for a 32-bit datapath. After a full-word load it pulls one byte or one halfword out of the loaded value and returns it right-justified with zeros above. Before a narrow store it copies the lowest byte or halfword into every lane of the word, so whichever lane the bus writes already holds the right data.

The lane to extract comes from one of two places. In the dynamic forms it is taken from the low bits of an address held in a selector register. In the static forms it is taken from an immediate field. Lanes are numbered little-endian: lane 0 is bits [7:0]. A 3-bit operation code picks the function. The result appears on the output in the same cycle, with no register on the path.

Top module: `lane_unit`

## Requirements
- R1: With op code 3'b000 (dynamic byte extract), result bits [7:0] equal byte n of the operand, where n = sel[1:0] and byte 0 is operand bits [7:0]. Result bits [31:8] are zero.
- R2: With op code 3'b001 (static byte extract), result bits [7:0] equal byte n of the operand, where n = imm[1:0]. Result bits [31:8] are zero.
- R3: With op code 3'b010 (dynamic halfword extract), result bits [15:0] equal halfword sel[1] of the operand, where halfword 0 is bits [15:0]. Result bits [31:16] are zero.
- R4: For op code 3'b010, sel[0] has no effect on the result.
- R5: With op code 3'b011 (static halfword extract), result bits [15:0] equal halfword imm[0] of the operand and bits [31:16] are zero. imm[1] has no effect.
- R6: With op code 3'b100 (byte replicate), all four byte lanes of the result equal operand bits [7:0].
- R7: With op code 3'b101 (halfword replicate), both halves of the result equal operand bits [15:0].
- R8: Op codes 3'b110 and 3'b111 give an all-zero result.
- R9: The dynamic extract codes (3'b000 and 3'b010) ignore imm. The static extract codes (3'b001 and 3'b011) ignore sel.
- R10: The replicate codes (3'b100 and 3'b101) ignore both sel and imm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code |
| operand_i | input | 32 | Word to extract from or replicate |
| sel_i | input | 2 | Low address bits of the selector register |
| imm_i | input | 2 | Immediate lane index |
| result_o | output | 32 | Aligned or replicated word |

## Verification
The selector bits and the immediate index are always present together. The op code alone decides which of them steers the lane multiplexers. The sweep drives every combination of sel and imm under every op code, so each vector offers two competing lane indices, and often two different ones. Each result is judged against an arithmetic shift-and-mask model that reads only the index the op code names. A second set of vectors changes only the index that should be ignored and checks that the result stays the same.

// File: rtl/lane_pkg.sv
package lane_pkg;
   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_XB_DYN = 3'b000,
      OP_XB_IMM = 3'b001,
      OP_XH_DYN = 3'b010,
      OP_XH_IMM = 3'b011,
      OP_REP_B  = 3'b100,
      OP_REP_H  = 3'b101
   } lane_op_e;
endpackage

// File: rtl/lane_extract.sv
// Picks piece idx_i of width PIECE_W out of word_i (piece 0 = LSBs).
module lane_extract #(
   parameter int DATA_W    = 32,
   parameter int PIECE_W   = 8,
   parameter bit SHIFT_MUX = 1'b0,
   localparam int NP = DATA_W / PIECE_W,
   localparam int IW = $clog2(NP)
) (
   input  logic [DATA_W-1:0]  word_i,
   input  logic [IW-1:0]      idx_i,
   output logic [PIECE_W-1:0] piece_o
);
   generate
      if (SHIFT_MUX) begin : g_shift
         logic [DATA_W-1:0] shifted;
         assign shifted = word_i >> (int'(idx_i) * PIECE_W);
         assign piece_o = shifted[PIECE_W-1:0];
      end else begin : g_andor
         logic [NP-1:0][PIECE_W-1:0] gated;
         for (genvar p = 0; p < NP; p++) begin : g_pc
            assign gated[p] = (idx_i == IW'(p)) ? word_i[p*PIECE_W +: PIECE_W]
                                                : '0;
         end
         always_comb begin
            piece_o = '0;
            for (int p = 0; p < NP; p++) piece_o = piece_o | gated[p];
         end
      end
   endgenerate
endmodule

// File: rtl/lane_fill.sv
// Copies one piece into every piece position of the word.
module lane_fill #(
   parameter int DATA_W  = 32,
   parameter int PIECE_W = 8,
   localparam int NP = DATA_W / PIECE_W
) (
   input  logic [PIECE_W-1:0] piece_i,
   output logic [DATA_W-1:0]  word_o
);
   generate
      for (genvar p = 0; p < NP; p++) begin : g_rep
         assign word_o[p*PIECE_W +: PIECE_W] = piece_i;
      end
   endgenerate
endmodule

// File: rtl/lane_unit.sv
module lane_unit #(
   parameter int DATA_W    = 32,
   parameter int LANE_W    = 8,
   parameter bit SHIFT_MUX = 1'b0,
   localparam int NB    = DATA_W / LANE_W,
   localparam int IDX_W = $clog2(NB)
) (
   input  logic [lane_pkg::OP_W-1:0] op_i,
   input  logic [DATA_W-1:0]         operand_i,
   input  logic [IDX_W-1:0]          sel_i,
   input  logic [IDX_W-1:0]          imm_i,
   output logic [DATA_W-1:0]         result_o
);
   import lane_pkg::*;

   localparam int HALF_W = 2 * LANE_W;
   localparam int NH     = DATA_W / HALF_W;
   localparam int HIW    = $clog2(NH);

   generate
      if (DATA_W % HALF_W != 0) begin : g_bad_width
         $error("lane_unit: DATA_W must be a multiple of two lanes");
      end
      if (NH < 2 || (1 << HIW) != NH) begin : g_bad_count
         $error("lane_unit: halfword count must be a power of two, at least 2");
      end
   endgenerate

   logic [IDX_W-1:0]  byte_idx;
   logic [HIW-1:0]    half_idx;
   logic [LANE_W-1:0] byte_pc;
   logic [HALF_W-1:0] half_pc;
   logic [DATA_W-1:0] byte_rep;
   logic [DATA_W-1:0] half_rep;

   // The op code decides whether the register or the immediate steers.
   assign byte_idx = (op_i == OP_XB_IMM) ? imm_i : sel_i;
   assign half_idx = (op_i == OP_XH_IMM) ? imm_i[HIW-1:0]
                                         : sel_i[IDX_W-1 -: HIW];

   lane_extract #(.DATA_W(DATA_W), .PIECE_W(LANE_W), .SHIFT_MUX(SHIFT_MUX)) u_xb (
      .word_i(operand_i), .idx_i(byte_idx), .piece_o(byte_pc));

   lane_extract #(.DATA_W(DATA_W), .PIECE_W(HALF_W), .SHIFT_MUX(SHIFT_MUX)) u_xh (
      .word_i(operand_i), .idx_i(half_idx), .piece_o(half_pc));

   lane_fill #(.DATA_W(DATA_W), .PIECE_W(LANE_W)) u_fb (
      .piece_i(operand_i[LANE_W-1:0]), .word_o(byte_rep));

   lane_fill #(.DATA_W(DATA_W), .PIECE_W(HALF_W)) u_fh (
      .piece_i(operand_i[HALF_W-1:0]), .word_o(half_rep));

   always_comb begin
      case (op_i)
         OP_XB_DYN, OP_XB_IMM: result_o = DATA_W'(byte_pc);
         OP_XH_DYN, OP_XH_IMM: result_o = DATA_W'(half_pc);
         OP_REP_B:             result_o = byte_rep;
         OP_REP_H:             result_o = half_rep;
         default:              result_o = '0;
      endcase
   end
endmodule

// File: rtl/lane_unit_chk.sv
module lane_unit_chk #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   localparam int NB    = DATA_W / LANE_W,
   localparam int IDX_W = $clog2(NB)
) (
   input logic [lane_pkg::OP_W-1:0] op_i,
   input logic [DATA_W-1:0]         operand_i,
   input logic [IDX_W-1:0]          sel_i,
   input logic [IDX_W-1:0]          imm_i,
   input logic [DATA_W-1:0]         result_o
);
   import lane_pkg::*;
   localparam int HALF_W = 2 * LANE_W;
   localparam int NH     = DATA_W / HALF_W;

   always_comb begin
      if (!$isunknown({op_i, operand_i, sel_i, imm_i})) begin
         if (op_i == OP_XB_DYN)
            a_r1_byte_dyn: assert (result_o[LANE_W-1:0] == operand_i[int'(sel_i)*LANE_W +: LANE_W]
                                   && result_o[DATA_W-1:LANE_W] == '0)
               else $error("R1 dynamic byte extract mismatch");
         if (op_i == OP_XB_IMM)
            a_r2_byte_imm: assert (result_o[LANE_W-1:0] == operand_i[int'(imm_i)*LANE_W +: LANE_W]
                                   && result_o[DATA_W-1:LANE_W] == '0)
               else $error("R2 static byte extract mismatch");
         if (op_i == OP_XH_DYN)  // R4: index uses sel_i >> 1 only
            a_r3_half_dyn: assert (result_o[HALF_W-1:0] == operand_i[int'(sel_i >> 1)*HALF_W +: HALF_W]
                                   && result_o[DATA_W-1:HALF_W] == '0)
               else $error("R3 dynamic halfword extract mismatch");
         if (op_i == OP_XH_IMM)
            a_r5_half_imm: assert (result_o[HALF_W-1:0] == operand_i[(int'(imm_i) % NH)*HALF_W +: HALF_W]
                                   && result_o[DATA_W-1:HALF_W] == '0)
               else $error("R5 static halfword extract mismatch");
         if (op_i == OP_REP_B)
            a_r6_rep_byte: assert (result_o == {NB{operand_i[LANE_W-1:0]}})
               else $error("R6 byte replicate mismatch");
         if (op_i == OP_REP_H)
            a_r7_rep_half: assert (result_o == {NH{operand_i[HALF_W-1:0]}})
               else $error("R7 halfword replicate mismatch");
         if (op_i[2:1] == 2'b11)
            a_r8_unused_zero: assert (result_o == '0)
               else $error("R8 unused code not zero");
      end
   end
endmodule

bind lane_unit lane_unit_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
   .op_i(op_i), .operand_i(operand_i), .sel_i(sel_i), .imm_i(imm_i), .result_o(result_o));

// File: tb/sim_lane_unit.sv
module sim_lane_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  op  = '0;
   logic [31:0] opd = '0;
   logic [1:0]  sel = '0;
   logic [1:0]  imm = '0;
   logic [31:0] result;

   int n_vec  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   lane_unit u0 (.op_i(op), .operand_i(opd), .sel_i(sel), .imm_i(imm), .result_o(result));

   function automatic logic [31:0] model(logic [2:0] o, logic [31:0] w,
                                         logic [1:0] s, logic [1:0] i);
      case (o)
         3'd0:    return (w >> (8 * s)) & 32'h0000_00FF;
         3'd1:    return (w >> (8 * i)) & 32'h0000_00FF;
         3'd2:    return (w >> (16 * s[1])) & 32'h0000_FFFF;
         3'd3:    return (w >> (16 * i[0])) & 32'h0000_FFFF;
         3'd4:    return (w & 32'hFF) * 32'h0101_0101;
         3'd5:    return (w & 32'hFFFF) * 32'h0001_0001;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(logic [2:0] o);
      case (o)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R5";
         3'd4: return "R6";
         3'd5: return "R7";
         default: return "R8";
      endcase
   endfunction

   function automatic logic [31:0] pattern(int k);
      case (k)
         0: return 32'h0000_0000;
         1: return 32'hFFFF_FFFF;
         2: return 32'h8765_4321;
         3: return 32'hA1B2_C3D4;
         4: return 32'h0000_00FF;
         5: return 32'hFF00_0000;
         default: return (32'h9E37_79B9 * k) ^ (32'h7F4A_7C15 >> k);
      endcase
   endfunction

   task automatic apply(logic [2:0] o, logic [31:0] w, logic [1:0] s,
                        logic [1:0] i, logic [31:0] exp, string tag);
      @(negedge clk);
      op = o; opd = w; sel = s; imm = i;
      #1;
      n_vec++;
      if (result !== exp) begin
         n_fail++;
         $display("FAIL %s: op=%0d opd=%h sel=%0d imm=%0d got %h expected %h",
                  tag, o, w, s, i, result, exp);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      // R1: idle inputs (all zero) during reset give a zero result
      #1;
      n_vec++;
      if (result !== 32'h0) begin
         n_fail++;
         $display("FAIL R1 reset: got %h expected %h", result, 32'h0);
      end
      rst = 1'b0;

      // Full sweep: every op, every sel, every imm, several operands
      for (int k = 0; k < 12; k++)
         for (int o = 0; o < 8; o++)
            for (int s = 0; s < 4; s++)
               for (int i = 0; i < 4; i++)
                  apply(3'(o), pattern(k), 2'(s), 2'(i),
                        model(3'(o), pattern(k), 2'(s), 2'(i)), tag_of(3'(o)));

      // Ignored-input checks with fixed expected values
      apply(3'd2, 32'hA1B2_C3D4, 2'd2, 2'd0, 32'h0000_A1B2, "R4");
      apply(3'd2, 32'hA1B2_C3D4, 2'd3, 2'd0, 32'h0000_A1B2, "R4");
      apply(3'd2, 32'hA1B2_C3D4, 2'd1, 2'd2, 32'h0000_C3D4, "R4");
      apply(3'd0, 32'hA1B2_C3D4, 2'd1, 2'd3, 32'h0000_00C3, "R9");
      apply(3'd1, 32'hA1B2_C3D4, 2'd3, 2'd0, 32'h0000_00D4, "R9");
      apply(3'd3, 32'hA1B2_C3D4, 2'd2, 2'd2, 32'h0000_C3D4, "R5");
      apply(3'd3, 32'hA1B2_C3D4, 2'd0, 2'd1, 32'h0000_A1B2, "R9");
      apply(3'd4, 32'hA1B2_C3D4, 2'd3, 2'd3, 32'hD4D4_D4D4, "R10");
      apply(3'd5, 32'hA1B2_C3D4, 2'd2, 2'd1, 32'hC3D4_C3D4, "R10");
      apply(3'd6, 32'hFFFF_FFFF, 2'd1, 2'd1, 32'h0000_0000, "R8");
      apply(3'd7, 32'hFFFF_FFFF, 2'd2, 2'd3, 32'h0000_0000, "R8");

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 50000 && !done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end
endmodule